// File: doc/BRIEF.md
# Multi-Resolution Edge-Aligned PWM Bank

This block drives a small bank of pulse-width-modulated outputs from one shared 16-bit timebase. The timebase advances by one on every cycle where the `tick` strobe is high, so the PWM clock is the block clock divided down by whatever strobe the chip supplies. Each channel compares only the low N bits of that timebase against the low N bits of its own compare word. N is either a common narrow width of 8, 9, 10 or 11 bits, shared by every narrow channel, or a full 16 bits chosen per channel.

Within each period of 2^N timebase steps a channel rises once, when the counter reaches its compare value. It falls once, when the low N counter bits wrap to zero. All narrow channels therefore fall on the same edge. Every channel also has a polarity-invert bit and an enable. The compare word, the wide/narrow choice and the narrow width are held in per-channel shadow copies. These copies reload only at that channel's wrap, so a duty-cycle change never cuts a period short. All configuration arrives on plain input ports, and the outputs come straight from flip-flops.

Top module: `pwm_bank`

## Requirements
- R1: The timebase `count_o` is 0 after reset, increases by one on each clock where `tick` is 1, holds its value where `tick` is 0, and wraps from 0xFFFF to 0x0000.
- R2: The active width N is 16 when the channel's shadowed `wide_mode` bit is 1. Otherwise N is 8 + `res_sel` (res_sel 0,1,2,3 gives 8,9,10,11). Compare and counter bits at position N and above have no effect on the output.
- R3: A wrap event occurs on a tick where the counter's new value has its low N bits all zero. A wrap drives the channel low before inversion. When the wrap coincides with a match, the wrap wins, so a compare whose low N bits are zero gives 0% duty.
- R4: A match event occurs on a tick where the low N bits of the counter's new value equal the low N bits of the shadowed compare word. It drives the channel high before inversion.
- R5: When `invert[i]` is 1, `pwm_out[i]` is the complement of the channel's pre-inversion level.
- R6: When `enable[i]` is 0, the pre-inversion level of channel i goes low on the next clock and stays low. After re-enable, it stays low until the next match.
- R7: A channel's shadow copies of its compare word, `wide_mode` bit and `res_sel` load from the inputs while `rst` is high and on that channel's wrap events, and at no other time.
- R8: `pwm_out` and `count_o` are registered. A level change appears on the same clock edge at which `count_o` takes the value that caused it. After reset, `pwm_out` is 0.
- R9: All enabled, non-inverted narrow channels are low whenever the low 8 bits of `count_o` are zero at 8-bit width, so their falling edges coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase advance strobe |
| res_sel | input | 2 | Shared narrow width select, N = 8 + res_sel |
| wide_mode | input | NCH | Per-channel 16-bit width select |
| invert | input | NCH | Per-channel output polarity invert |
| enable | input | NCH | Per-channel enable; 0 forces the level low |
| compare | input | NCH*16 | Compare words, channel i at bits [16*i +: 16] |
| count_o | output | 16 | Current timebase value |
| pwm_out | output | NCH | Registered PWM outputs |

## Verification
Four channels first run at 8-bit width with a continuous strobe and compare values spread across the period. One compare word carries high bits that must be ignored. A gapped strobe then tells counter holding apart from advancing. Mid-period compare changes and width changes to 9, 10 and 11 bits show whether the shadow copies reload only at the wrap. A zero compare exercises the wrap-over-match priority, and a pass through a full 16-bit period covers the wide mode and the 0xFFFF wrap. Invert and enable patterns are varied per channel, so that a polarity or gating fault on a single channel shows up against its neighbours.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int CNT_W      = 16;
    localparam int RES_SEL_W  = 2;
    localparam int NARROW_MIN = 8;

    typedef logic [CNT_W-1:0] count_t;

    // Per-channel configuration captured at each wrap
    typedef struct packed {
        count_t                 cmp;
        logic                   wide;
        logic [RES_SEL_W-1:0]   res;
    } chan_cfg_t;

    // Mask of the active low bits for a channel
    function automatic count_t width_mask(input logic wide, input logic [RES_SEL_W-1:0] res);
        count_t m;
        int     n;
        n = wide ? CNT_W : NARROW_MIN + int'(res);
        m = '0;
        for (int b = 0; b < CNT_W; b++) begin
            if (b < n) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_bank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    output count_t cnt,
    output count_t cnt_next
);

    assign cnt_next = cnt + count_t'(1);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= cnt_next;
    end

    // R1: advances by one per strobe
    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == count_t'($past(cnt) + count_t'(1))));

    // R1: holds without a strobe
    p_count_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  count_t    cnt_next,
    input  chan_cfg_t cfg_in,
    input  logic      enable,
    input  logic      invert,
    output logic      pwm_o
);

    chan_cfg_t shadow;
    count_t    mask;
    logic      wrap;
    logic      hit;
    logic      level_q;
    logic      level_d;

    assign mask = width_mask(shadow.wide, shadow.res);
    assign wrap = tick && ((cnt_next & mask) == '0);
    assign hit  = tick && (((cnt_next ^ shadow.cmp) & mask) == '0);

    // Wrap has priority over a coincident match
    always_comb begin
        if (!enable)   level_d = 1'b0;
        else if (wrap) level_d = 1'b0;
        else if (hit)  level_d = 1'b1;
        else           level_d = level_q;
    end

    always_ff @(posedge clk) begin
        if (rst || wrap) shadow <= cfg_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            pwm_o   <= 1'b0;
        end else begin
            level_q <= level_d;
            pwm_o   <= level_d ^ invert;
        end
    end

    // R6: a disabled channel is low before inversion
    p_disabled_low_r6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !level_q);

    // R7: shadow copy only moves at a wrap
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(shadow));

    // R5: output is the level xor the sampled polarity
    p_polarity_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pwm_o == (level_q ^ $past(invert))));

    // R3: a wrap always leaves the level low
    p_wrap_low_r3: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !level_q);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [RES_SEL_W-1:0] res_sel,
    input  logic [NCH-1:0]       wide_mode,
    input  logic [NCH-1:0]       invert,
    input  logic [NCH-1:0]       enable,
    input  logic [NCH*CNT_W-1:0] compare,
    output logic [CNT_W-1:0]     count_o,
    output logic [NCH-1:0]       pwm_out
);

    count_t cnt;
    count_t cnt_next;

    pwm_timebase u_timebase (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cnt      (cnt),
        .cnt_next (cnt_next)
    );

    assign count_o = cnt;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        chan_cfg_t cfg;
        assign cfg.cmp  = compare[i*CNT_W +: CNT_W];
        assign cfg.wide = wide_mode[i];
        assign cfg.res  = res_sel;

        pwm_channel u_chan (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .cnt_next (cnt_next),
            .cfg_in   (cfg),
            .enable   (enable[i]),
            .invert   (invert[i]),
            .pwm_o    (pwm_out[i])
        );
    end

    // R8: outputs are cleared while in reset
    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |=> (pwm_out == '0 && count_o == '0));

endmodule

// File: tb/pwm_bank_test.sv
`timescale 1ns/1ps
module pwm_bank_test;

    localparam int NCH = 4;
    localparam int CW  = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              tick;
    logic [1:0]        res_sel;
    logic [NCH-1:0]    wide_mode;
    logic [NCH-1:0]    invert;
    logic [NCH-1:0]    enable;
    logic [NCH*CW-1:0] compare;
    logic [CW-1:0]     count_o;
    logic [NCH-1:0]    pwm_out;

    pwm_bank #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst), .tick(tick), .res_sel(res_sel),
        .wide_mode(wide_mode), .invert(invert), .enable(enable),
        .compare(compare), .count_o(count_o), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    string tag = "R8";
    int tick_mode = 0;
    bit align_chk = 0;

    // Behavioural reference state
    int m_cnt;
    int sh_cmp [NCH];
    int sh_wide[NCH];
    int sh_res [NCH];
    int lvl    [NCH];
    int m_out  [NCH];

    function automatic int cmp_of(int ch);
        return int'(compare[ch*CW +: CW]);
    endfunction

    task automatic model_step();
        int nxt;
        if (rst) begin
            m_cnt = 0;
            for (int c = 0; c < NCH; c++) begin
                sh_cmp[c] = cmp_of(c); sh_wide[c] = int'(wide_mode[c]);
                sh_res[c] = int'(res_sel); lvl[c] = 0; m_out[c] = 0;
            end
        end else begin
            nxt = (m_cnt + 1) % 65536;
            for (int c = 0; c < NCH; c++) begin
                int bits = sh_wide[c] != 0 ? 16 : 8 + sh_res[c];
                int msk  = (1 << bits) - 1;
                bit wr   = tick && ((nxt & msk) == 0);
                bit mt   = tick && ((nxt & msk) == (sh_cmp[c] & msk));
                if (!enable[c])  lvl[c] = 0;
                else if (wr)     lvl[c] = 0;
                else if (mt)     lvl[c] = 1;
                m_out[c] = lvl[c] ^ int'(invert[c]);
                if (wr) begin
                    sh_cmp[c] = cmp_of(c); sh_wide[c] = int'(wide_mode[c]);
                    sh_res[c] = int'(res_sel);
                end
            end
            if (tick) m_cnt = nxt;
        end
    endtask

    task automatic check_now();
        checks++;
        if (int'(count_o) != m_cnt) begin
            fails++;
            $display("FAIL R1 count: actual %0h expected %0h", count_o, m_cnt);
        end
        for (int c = 0; c < NCH; c++) begin
            checks++;
            if (int'(pwm_out[c]) != m_out[c]) begin
                fails++;
                $display("FAIL %s ch%0d at count %0h: actual %0b expected %0b",
                         tag, c, count_o, pwm_out[c], m_out[c]);
            end
        end
        if (align_chk && count_o[7:0] == 8'h00) begin
            checks++;
            if (pwm_out != '0) begin
                fails++;
                $display("FAIL R9 aligned wrap: actual %b expected 0000", pwm_out);
            end
        end
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) begin
            tick = (tick_mode == 0) ? 1'b1 : ((k % 3) != 0);
            @(posedge clk);
            model_step();
            @(negedge clk);
            check_now();
        end
    endtask

    task automatic set_cmp(int ch, int v);
        compare[ch*CW +: CW] = CW'(v);
    endtask

    initial begin
        rst = 1'b1; tick = 1'b0; res_sel = 2'd0; wide_mode = '0;
        invert = '0; enable = '1; compare = '0;
        set_cmp(0, 'h10); set_cmp(1, 'h80); set_cmp(2, 'hF0);
        set_cmp(3, 'h7140);            // R2: high bits ignored at 8-bit width
        tag = "R8";                    // reset state
        run(4);
        rst = 1'b0;
        tag = "R4"; run(600);          // match rise, wrap fall
        tag = "R8"; tick_mode = 1; run(600);   // gapped strobe
        tick_mode = 0;
        tag = "R5"; invert = 4'b1010; run(600);
        invert = '0;
        tag = "R6"; enable = 4'b0101; run(300);
        enable = '1; run(300);
        tag = "R7"; set_cmp(0, 'h40); set_cmp(1, 'h20); run(150);
        set_cmp(2, 'h08); run(450);
        tag = "R2"; res_sel = 2'd1; set_cmp(3, 'hF1C0); run(600);
        res_sel = 2'd2; set_cmp(1, 'h3F0); run(1100);
        res_sel = 2'd3; set_cmp(2, 'h7FF); run(2200);
        tag = "R3"; res_sel = 2'd0; set_cmp(0, 'h0000); set_cmp(1, 'h0300); run(2200);
        tag = "R2"; wide_mode = 4'b0011; set_cmp(0, 'h0100); set_cmp(1, 'h8000);
        run(70000);                    // full 16-bit period, 0xFFFF wrap (R1)
        tag = "R9"; wide_mode = '0; res_sel = 2'd0;
        set_cmp(0, 'h11); set_cmp(1, 'h55); set_cmp(2, 'hA0); set_cmp(3, 'hFE);
        run(66000);                    // let wide channels drain back to narrow
        align_chk = 1; run(600);
        align_chk = 0;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule